// File: doc/BRIEF.md
# Grouped-Refill Tag and Replacement Controller

This block keeps the tags and the replacement state of a two-way set-associative cache of 8 KB with 64-byte lines. It manages lines in groups rather than one at a time. A group is eight consecutive line indices that share one tag, and it is selected by the upper index bits. Each way holds one tag entry and one valid bit per group. Each group has one recency bit, so the replacement table holds eight bits instead of sixty-four.

A lookup presents a line address and an access kind (tile or line). Two cycles later the block answers with hit or miss and a way. On a hit the way is where the line lives. On a miss the way is the victim chosen for the refill. A miss raises a refill request that carries the byte base address of the whole group. The block then takes eight line-sized beats and forwards each beat as a write into the chosen way of the data array. It commits the tag at the final beat. No lookup is accepted between the miss and the last beat.

Top module: `tileset_tag_ctrl`

## Requirements
- R1: After reset every group is empty in both ways, `lk_ready` is 1, and `rsp_valid`, `fill_req_valid` and `dwr_en` are 0.
- R2: A lookup accepted at a clock edge (`lk_valid` and `lk_ready` both 1) gives exactly one response, with `rsp_valid` high in the cycle after the next edge. `rsp_set` is the 6-bit line index: bits [5:0] of `lk_line`, where bits [5:3] select the group and bits [2:0] select the member.
- R3: A response is a hit (`rsp_hit`=1) only when the addressed group holds the tag `lk_line[25:6]` valid in a way. `rsp_way` then names that way. A group never holds one tag in both ways.
- R4: After one refill, all eight members of that group hit in the filled way.
- R5: On a miss `rsp_way` is the victim. The victim is way 0 if way 0 of the group is invalid. Otherwise it is way 1 if way 1 is invalid. Otherwise it is the least recently used way of that group.
- R6: A hit or a completed refill makes the way used the most recent for that group only. Other groups keep their own recency state.
- R7: A miss raises `fill_req_valid` with `fill_req_addr` = {tag, group, 9'b0}. Both are held stable until `fill_req_ready` is seen. A hit raises no request.
- R8: Each refill beat accepted while the block is filling gives, one cycle later, `dwr_en`=1 with `dwr_way` equal to the victim, `dwr_set` = {group, beat number 0..7}, and `dwr_data` equal to the beat. Gaps in `fill_beat_valid` are allowed.
- R9: `lk_ready` is 0 from the acceptance of a missing lookup until the edge that takes the eighth beat, and is 1 in the cycle after that edge.
- R10: `rsp_tile` returns the `lk_tile` value of the lookup. The access kind has no effect on hit, way or refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_line | input | 26 | Line address: tag [25:6], group [5:3], member [2:0] |
| lk_tile | input | 1 | Access kind: 1 tile, 0 line |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 1 | Hit way, or victim way on a miss |
| rsp_tile | output | 1 | Access kind of the answered lookup |
| rsp_set | output | 6 | Line index of the answered lookup |
| fill_req_valid | output | 1 | Group refill request |
| fill_req_ready | input | 1 | Next level takes the request |
| fill_req_addr | output | 32 | Byte base address of the group |
| fill_beat_valid | input | 1 | Refill beat present |
| fill_beat_data | input | 512 | One line of refill data |
| dwr_en | output | 1 | Data array write strobe |
| dwr_way | output | 1 | Data array write way |
| dwr_set | output | 6 | Data array write line index |
| dwr_data | output | 512 | Data array write line |

## Verification
The bench builds the block with its defaults: 8 KB, 64-byte lines and eight-line groups. That gives eight groups, a 20-bit tag and a three-bit beat count. A pool of three tags spread over all eight groups puts every group through empty-way fills, hits in both ways and recency-driven evictions within a few hundred lookups. Random request delays and beat gaps exercise the held request and the stall window around each refill.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_REQ  = 2'd2,
    ST_FILL = 2'd3
  } tsc_state_e;
endpackage

// File: rtl/tsc_tag_bank.sv
// One way's tag store: one entry per group, synchronous read for block RAM.
module tsc_tag_bank #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 20,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/tsc_repl_state.sv
// Valid bits per way and group, plus one recency bit per group.
module tsc_repl_state #(
  parameter int GRP_W = 3,
  localparam int GROUPS = 1 << GRP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [GRP_W-1:0] rd_grp,
  output logic [1:0]       rd_valid,
  output logic             rd_victim,
  input  logic             upd_en,
  input  logic [GRP_W-1:0] upd_grp,
  input  logic             upd_way,
  input  logic             upd_fill
);
  logic [GROUPS-1:0] vld_w0, vld_w1;
  logic [GROUPS-1:0] evict_q;  // way to evict next, per group

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_w0  <= '0;
      vld_w1  <= '0;
      evict_q <= '0;
    end else if (upd_en) begin
      evict_q[upd_grp] <= ~upd_way;
      if (upd_fill) begin
        if (upd_way) vld_w1[upd_grp] <= 1'b1;
        else         vld_w0[upd_grp] <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_valid = {vld_w1[rd_grp], vld_w0[rd_grp]};
    if (!rd_valid[0])      rd_victim = 1'b0;
    else if (!rd_valid[1]) rd_victim = 1'b1;
    else                   rd_victim = evict_q[rd_grp];
  end

  // R6: the way just used is no longer the eviction candidate of its group
  assert_recency_update_R6: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> evict_q[$past(upd_grp)] != $past(upd_way));

  // R4: a completed refill leaves the filled way valid for the group
  assert_fill_valid_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_fill) |=> (($past(upd_way) ? vld_w1[$past(upd_grp)] : vld_w0[$past(upd_grp)]) == 1'b1));
endmodule

// File: rtl/tileset_tag_ctrl.sv
module tileset_tag_ctrl
  import tsc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 8192,
  parameter int LINE_BYTES  = 64,
  parameter int GROUP_LINES = 8,
  localparam int WAYS    = 2,
  localparam int SETS    = CACHE_BYTES / (LINE_BYTES * WAYS),
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int IDX_W   = $clog2(SETS),
  localparam int MEM_W   = $clog2(GROUP_LINES),
  localparam int GRP_W   = IDX_W - MEM_W,
  localparam int GROUPS  = 1 << GRP_W,
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_AW = ADDR_W - OFF_W,
  localparam int DATA_W  = LINE_BYTES * 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_valid,
  output logic               lk_ready,
  input  logic [LINE_AW-1:0] lk_line,
  input  logic               lk_tile,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_way,
  output logic               rsp_tile,
  output logic [IDX_W-1:0]   rsp_set,
  output logic               fill_req_valid,
  input  logic               fill_req_ready,
  output logic [ADDR_W-1:0]  fill_req_addr,
  input  logic               fill_beat_valid,
  input  logic [DATA_W-1:0]  fill_beat_data,
  output logic               dwr_en,
  output logic               dwr_way,
  output logic [IDX_W-1:0]   dwr_set,
  output logic [DATA_W-1:0]  dwr_data
);
  tsc_state_e state_q;

  logic [TAG_W-1:0] a_tag_q;
  logic [GRP_W-1:0] a_grp_q;
  logic [MEM_W-1:0] a_mem_q;
  logic             a_tile_q;
  logic             way_q;
  logic [MEM_W-1:0] beat_q;

  logic [TAG_W-1:0] tag_rd [WAYS];
  logic [WAYS-1:0]  hit_vec;
  logic [1:0]       rd_valid;
  logic             rd_victim;
  logic             accept, hit, hit_way, last_beat, beat_take;
  logic             upd_en, upd_way;

  wire [GRP_W-1:0] lk_grp = lk_line[IDX_W-1:MEM_W];

  // Lookup handshake and request are decoded from the state register only
  always_comb begin
    lk_ready       = (state_q == ST_IDLE);
    fill_req_valid = (state_q == ST_REQ);
    fill_req_addr  = {a_tag_q, a_grp_q, {(MEM_W + OFF_W){1'b0}}};
    accept         = lk_valid && lk_ready;
    beat_take      = (state_q == ST_FILL) && fill_beat_valid;
    last_beat      = beat_take && (beat_q == MEM_W'(GROUP_LINES - 1));
  end

  // Tag banks, one per way
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tsc_tag_bank #(.DEPTH(GROUPS), .WIDTH(TAG_W)) u_bank (
      .clk     (clk),
      .rd_en   (accept),
      .rd_addr (lk_grp),
      .rd_data (tag_rd[w]),
      .wr_en   (last_beat && (way_q == 1'(w))),
      .wr_addr (a_grp_q),
      .wr_data (a_tag_q)
    );
    assign hit_vec[w] = rd_valid[w] && (tag_rd[w] == a_tag_q);
  end

  always_comb begin
    hit     = |hit_vec;
    hit_way = hit_vec[1];
    upd_en  = ((state_q == ST_LOOK) && hit) || last_beat;
    upd_way = last_beat ? way_q : hit_way;
  end

  tsc_repl_state #(.GRP_W(GRP_W)) u_repl (
    .clk       (clk),
    .rst       (rst),
    .rd_grp    (a_grp_q),
    .rd_valid  (rd_valid),
    .rd_victim (rd_victim),
    .upd_en    (upd_en),
    .upd_grp   (a_grp_q),
    .upd_way   (upd_way),
    .upd_fill  (last_beat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      a_tag_q   <= '0;
      a_grp_q   <= '0;
      a_mem_q   <= '0;
      a_tile_q  <= 1'b0;
      way_q     <= 1'b0;
      beat_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= 1'b0;
      rsp_tile  <= 1'b0;
      rsp_set   <= '0;
      dwr_en    <= 1'b0;
      dwr_way   <= 1'b0;
      dwr_set   <= '0;
      dwr_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      dwr_en    <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          a_tag_q  <= lk_line[LINE_AW-1:IDX_W];
          a_grp_q  <= lk_grp;
          a_mem_q  <= lk_line[MEM_W-1:0];
          a_tile_q <= lk_tile;
          state_q  <= ST_LOOK;
        end
        ST_LOOK: begin
          rsp_valid <= 1'b1;
          rsp_hit   <= hit;
          rsp_way   <= hit ? hit_way : rd_victim;
          rsp_tile  <= a_tile_q;
          rsp_set   <= {a_grp_q, a_mem_q};
          way_q     <= rd_victim;
          state_q   <= hit ? ST_IDLE : ST_REQ;
        end
        ST_REQ: if (fill_req_ready) begin
          beat_q  <= '0;
          state_q <= ST_FILL;
        end
        ST_FILL: if (beat_take) begin
          dwr_en   <= 1'b1;
          dwr_way  <= way_q;
          dwr_set  <= {a_grp_q, beat_q};
          dwr_data <= fill_beat_data;
          beat_q   <= beat_q + 1'b1;
          if (last_beat) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: every accepted lookup is answered two edges later
  assert_rsp_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_ready) |-> ##2 rsp_valid);

  // R3: a tag is never resident in both ways of a group
  assert_single_way_hit_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOK) |-> $onehot0(hit_vec));

  // R7: the refill request holds its address until taken
  assert_req_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (fill_req_valid && !fill_req_ready) |=> (fill_req_valid && $stable(fill_req_addr)));

  // R8: data array writes only follow accepted beats
  assert_write_after_beat_R8: assert property (@(posedge clk) disable iff (rst)
    dwr_en |-> $past(fill_beat_valid));

  // R9: a miss answer always comes with lookups stalled
  assert_stall_on_miss_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> !lk_ready);
endmodule

// File: tb/tileset_tag_ctrl_test.sv
`timescale 1ns/1ps
module tileset_tag_ctrl_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         lk_valid = 1'b0, lk_tile = 1'b0;
  logic [25:0]  lk_line = '0;
  logic         lk_ready, rsp_valid, rsp_hit, rsp_way, rsp_tile;
  logic [5:0]   rsp_set, dwr_set;
  logic         fill_req_valid, fill_req_ready = 1'b0;
  logic [31:0]  fill_req_addr;
  logic         fill_beat_valid = 1'b0;
  logic [511:0] fill_beat_data = '0, dwr_data;
  logic         dwr_en, dwr_way;

  tileset_tag_ctrl uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_line(lk_line), .lk_tile(lk_tile), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_tile(rsp_tile),
    .rsp_set(rsp_set), .fill_req_valid(fill_req_valid),
    .fill_req_ready(fill_req_ready), .fill_req_addr(fill_req_addr),
    .fill_beat_valid(fill_beat_valid), .fill_beat_data(fill_beat_data),
    .dwr_en(dwr_en), .dwr_way(dwr_way), .dwr_set(dwr_set), .dwr_data(dwr_data)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct packed { logic hit; logic way; logic tile; logic [5:0] set; } rsp_t;
  typedef struct packed { logic way; logic [5:0] set; logic [511:0] data; } wr_t;
  rsp_t  rsp_q[$];
  string req_q[$];
  wr_t   wr_q[$];

  // reference model of the tag state
  bit          mv [2][8];
  logic [19:0] mt [2][8];
  bit          ml [8];   // way to evict next

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compares design results with the expected items
  rsp_t  m_r;
  wr_t   m_w;
  string m_req;
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rsp_valid) begin
        if (rsp_q.size() == 0) check(0, "R2", "response without lookup", 1, 0);
        else begin
          m_r = rsp_q.pop_front();
          m_req = req_q.pop_front();
          check(rsp_hit == m_r.hit, m_req, "hit", 64'(rsp_hit), 64'(m_r.hit));
          check(rsp_way == m_r.way, m_req, "way", 64'(rsp_way), 64'(m_r.way));
          check(rsp_tile == m_r.tile, "R10", "kind echo", 64'(rsp_tile), 64'(m_r.tile));
          check(rsp_set == m_r.set, "R2", "line index", 64'(rsp_set), 64'(m_r.set));
        end
      end
      if (dwr_en) begin
        if (wr_q.size() == 0) check(0, "R8", "write without beat", 1, 0);
        else begin
          m_w = wr_q.pop_front();
          check(dwr_way == m_w.way, "R8", "write way", 64'(dwr_way), 64'(m_w.way));
          check(dwr_set == m_w.set, "R8", "write index", 64'(dwr_set), 64'(m_w.set));
          check(dwr_data == m_w.data, "R8", "write data", dwr_data[63:0], m_w.data[63:0]);
        end
      end
    end
  end

  // driver: one lookup, plus the refill when the model predicts a miss
  task automatic lookup(input logic [19:0] t, input logic [2:0] g, input logic [2:0] m,
                        input logic tl, input string req);
    logic hit, way;
    logic [31:0] base;
    rsp_t e;
    hit = 0; way = 0;
    for (int w = 0; w < 2; w++)
      if (mv[w][g] && mt[w][g] == t) begin hit = 1; way = w[0]; end
    if (!hit) way = !mv[0][g] ? 1'b0 : (!mv[1][g] ? 1'b1 : ml[g]);
    e = '{hit, way, tl, {g, m}};
    rsp_q.push_back(e);
    req_q.push_back(req);
    base = {t, g, 9'd0};
    check(lk_ready == 1, "R9", "ready before lookup", 64'(lk_ready), 1);
    lk_valid = 1; lk_line = {t, g, m}; lk_tile = tl;
    @(negedge clk);
    lk_valid = 0;
    @(negedge clk);   // response is visible here
    if (hit) begin
      ml[g] = ~way;
      check(fill_req_valid == 0, "R7", "no request on hit", 64'(fill_req_valid), 0);
      check(lk_ready == 1, "R9", "ready after hit", 64'(lk_ready), 1);
    end else begin
      check(lk_ready == 0, "R9", "stall on miss", 64'(lk_ready), 0);
      check(fill_req_valid == 1, "R7", "request on miss", 64'(fill_req_valid), 1);
      check(fill_req_addr == base, "R7", "request address", 64'(fill_req_addr), 64'(base));
      repeat ($urandom_range(0, 2)) begin
        @(negedge clk);
        check(fill_req_valid && fill_req_addr == base, "R7", "request held",
              64'(fill_req_addr), 64'(base));
      end
      fill_req_ready = 1;
      @(negedge clk);
      fill_req_ready = 0;
      for (int b = 0; b < 8; b++) begin
        logic [511:0] d;
        if ($urandom_range(0, 3) == 0) begin
          fill_beat_valid = 0;
          @(negedge clk);
          check(lk_ready == 0, "R9", "stall during refill", 64'(lk_ready), 0);
        end
        for (int k = 0; k < 16; k++) d[k*32 +: 32] = $urandom;
        fill_beat_valid = 1;
        fill_beat_data = d;
        wr_q.push_back('{way, {g, b[2:0]}, d});
        @(negedge clk);
      end
      fill_beat_valid = 0;
      check(lk_ready == 1, "R9", "resume after last beat", 64'(lk_ready), 1);
      mv[way][g] = 1; mt[way][g] = t; ml[g] = ~way;
    end
  endtask

  localparam logic [19:0] TA = 20'h00A5A, TB = 20'h00B00, TC = 20'h00C0F;

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state at the ports
    check(lk_ready == 1, "R1", "ready after reset", 64'(lk_ready), 1);
    check(rsp_valid == 0, "R1", "no response", 64'(rsp_valid), 0);
    check(fill_req_valid == 0, "R1", "no request", 64'(fill_req_valid), 0);
    check(dwr_en == 0, "R1", "no write", 64'(dwr_en), 0);

    lookup(TA, 3'd2, 3'd0, 0, "R1");  // empty group: miss into way 0
    lookup(TA, 3'd2, 3'd7, 1, "R4");  // another member hits, kind differs (R10)
    lookup(TA, 3'd2, 3'd7, 0, "R10"); // same line, other kind: still a hit
    lookup(TA, 3'd3, 3'd0, 0, "R6");  // another group is independent: miss way 0
    lookup(TB, 3'd2, 3'd3, 0, "R5");  // invalid way 1 taken first
    lookup(TA, 3'd2, 3'd5, 0, "R3");  // hit way 0, way 1 becomes victim
    lookup(TC, 3'd2, 3'd1, 1, "R5");  // evicts way 1 (least recent)
    lookup(TB, 3'd2, 3'd1, 0, "R6");  // TB gone; fill of way 1 made way 0 victim
    lookup(TC, 3'd2, 3'd6, 0, "R4");  // hit way 1
    lookup(TA, 3'd2, 3'd0, 1, "R6");  // evicts way 0 after the hit in way 1

    for (int i = 0; i < 400; i++) begin
      logic [19:0] t;
      case ($urandom_range(0, 2))
        0: t = TA;
        1: t = TB;
        default: t = TC;
      endcase
      lookup(t, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
             1'($urandom_range(0, 1)), "R5/R6");
    end
    repeat (3) @(negedge clk);
    check(rsp_q.size() == 0, "R2", "responses outstanding", 64'(rsp_q.size()), 0);
    check(wr_q.size() == 0, "R8", "writes outstanding", 64'(wr_q.size()), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule